// File: doc/BRIEF.md
# Double-Operand Execute Unit with Condition Codes

This unit executes the two-operand instruction group of a 16-bit minicomputer. Each accepted instruction supplies its four-bit major opcode, three further instruction bits, and already-fetched source and destination operand values, plus a flag saying whether the destination is a plain register. One cycle later the unit presents the result value, a result write-enable, a low-byte-only write qualifier, the new N/Z/V/C condition codes, and two exclusive strobes. One strobe raises a reserved-instruction trap. The other hands the instruction to a secondary decoder and carries the three extra opcode bits with it.

The supported operations are move, compare, bit test, bit clear and bit set, each in word and byte forms, plus word add and word subtract. The condition-code register is held inside the unit. A status-word write port can overwrite it, and that write beats whatever the instruction computes at the same edge.

A two-state controller sequences the outputs. ST_IDLE means no result is shown. ST_SHOW means the registered outputs belong to the instruction accepted at the previous edge. The transitions are ST_IDLE to ST_SHOW on an accepted instruction, ST_SHOW to ST_SHOW on a further instruction, ST_SHOW to ST_IDLE when none arrives, and ST_IDLE to ST_IDLE when none arrives. Reset returns the controller to ST_IDLE.

Top module: `dop_exec`

## Requirements
- R1: Major opcodes 0, 7 and 8 (hex; octal 00, 07, 10) raise `fwd_o` with `fwd_sel_o` equal to the `sub_sel_i` value that was accepted. Write-enable stays low and the condition codes are unchanged.
- R2: Major opcode F (octal 17) raises `trap_o`, keeps write-enable low and leaves the condition codes unchanged.
- R3: Opcodes 1 (move) and 9 (byte move) pass the source to the result and assert write-enable. V is cleared, Z is set when the moved value is zero, N takes the operand-size sign bit, and C is kept. Condition codes sit on `cc_o` as {N,Z,V,C}, with N at bit 3 and C at bit 0.
- R4: A byte move to a register destination (`dst_is_reg`=1) writes all 16 bits, sign-extending bit 7 into bits 15:8, with `result_lo_only`=0. Every other byte write has `result_lo_only`=1 and bits 15:8 of the result equal to zero.
- R5: Compare (opcodes 2 and A) forms src−dst masked to the operand size and writes nothing. C = src < dst (unsigned). V = the operand signs differ and the result sign equals the dst sign.
- R6: Subtract (opcode E, always word) writes dst−src. C = src > dst (unsigned). V = the operand signs differ and the result sign equals the src sign.
- R7: Add (opcode 6, always word) writes src+dst. C is the carry out of bit 15. V = the operands share a sign and the result sign differs from it.
- R8: Bit test (3/B) writes nothing. Bit clear (4/C) writes dst AND NOT src. Bit set (5/D) writes dst OR src. All three set N and Z from the value, clear V and keep C.
- R9: When opcode bit 3 is set, other than opcodes E and F, operands are masked to 8 bits and bit 7 is the sign bit. Otherwise bit 15 is the sign bit.
- R10: The outputs and `out_valid` appear exactly one cycle after `in_valid`. With no accepted instruction, `out_valid` and write-enable are low and the condition codes change only through the write port.
- R11: When `ccw_en` is high at an edge, `cc_o` takes `ccw_data` even if an instruction computes flags at the same edge.
- R12: After a synchronous reset (`rst_n` low), `out_valid` is 0 and `cc_o` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction accepted this edge |
| op_code | input | 4 | Instruction bits 15:12 |
| sub_sel_i | input | 3 | Instruction bits 11:9 |
| src_i | input | 16 | Source operand value |
| dst_i | input | 16 | Destination operand value |
| dst_is_reg | input | 1 | Destination is register-direct |
| ccw_en | input | 1 | Status-word write to the condition codes |
| ccw_data | input | 4 | Value for that write, {N,Z,V,C} |
| out_valid | output | 1 | Registered outputs are valid |
| result_o | output | 16 | Result value |
| result_we | output | 1 | Result must be written back |
| result_lo_only | output | 1 | Only the low byte is written |
| cc_o | output | 4 | Condition codes {N,Z,V,C} |
| trap_o | output | 1 | Reserved-instruction trap |
| fwd_o | output | 1 | Instruction belongs to the secondary decoder |
| fwd_sel_o | output | 3 | Bits 11:9 passed to that decoder |

## Verification
The directed cases cover several edge values. Add is tried with 7FFF+1 and FFFF+1: a design that swapped the overflow rules of add and subtract, or that dropped the carry, flags the wrong one. Compare and subtract use the same operand pair in opposite orders, so an implementation sharing one subtractor for both would get the sign and carry wrong on one of them. Byte cases use bit 7 with clean and dirty high bytes, which exposes sign tests left at bit 15 and byte moves that never sign-extend. Further cases catch C being clobbered by the logical operations, a trap or forward code that still updates the flags, and an instruction that overrides a status-word write at the same edge.

// File: rtl/dop_exec_pkg.sv
package dop_exec_pkg;

    typedef enum logic [2:0] {
        K_MOV,
        K_CMP,
        K_BIT,
        K_BIC,
        K_BIS,
        K_ADD,
        K_SUB,
        K_NONE
    } op_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } show_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;

endpackage

// File: rtl/dop_decode.sv
module dop_decode
    import dop_exec_pkg::*;
(
    input  logic [3:0] op_code,
    output op_kind_e   kind,
    output logic       is_byte,
    output logic       writes,
    output logic       is_fwd,
    output logic       is_trap
);

    always_comb begin
        kind    = K_NONE;
        is_fwd  = 1'b0;
        is_trap = 1'b0;
        unique case (op_code[2:0])
            3'd1: kind = K_MOV;
            3'd2: kind = K_CMP;
            3'd3: kind = K_BIT;
            3'd4: kind = K_BIC;
            3'd5: kind = K_BIS;
            3'd6: kind = op_code[3] ? K_SUB : K_ADD;
            3'd0: is_fwd = 1'b1;
            3'd7: begin
                is_fwd  = ~op_code[3];
                is_trap = op_code[3];
            end
            default: kind = K_NONE;
        endcase
        // word-only arithmetic ignores the size bit
        is_byte = op_code[3] && (op_code[2:0] != 3'd6) && (op_code[2:0] != 3'd7);
        writes  = (kind == K_MOV) || (kind == K_BIC) || (kind == K_BIS) ||
                  (kind == K_ADD) || (kind == K_SUB);
    end

endmodule

// File: rtl/dop_alu.sv
module dop_alu
    import dop_exec_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  op_kind_e       kind,
    input  logic           is_byte,
    input  logic           to_reg,
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   dst,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output logic           lo_only,
    output ccode_t         cc_out
);

    localparam int IW = $clog2(W);
    localparam logic [W-1:0] BYTE_MASK = W'((1 << BW) - 1);

    logic [W-1:0]  mask, s, d, t;
    logic [W:0]    sum;
    logic [IW-1:0] sb;
    logic          ss, ds, ts;

    always_comb begin
        mask = is_byte ? BYTE_MASK : '1;
        sb   = is_byte ? IW'(BW - 1) : IW'(W - 1);
        s    = src & mask;
        d    = dst & mask;
        sum  = {1'b0, s} + {1'b0, d};
        ss   = s[sb];
        ds   = d[sb];
        t    = '0;
        cc_out = '{n: 1'b0, z: 1'b0, v: 1'b0, c: c_in};
        unique case (kind)
            K_MOV: t = s;
            K_CMP: begin
                t = (s - d) & mask;
                cc_out.c = s < d;
            end
            K_BIT: t = s & d;
            K_BIC: t = d & ~s;
            K_BIS: t = d | s;
            K_ADD: begin
                t = sum[W-1:0];
                cc_out.c = sum[W];
            end
            K_SUB: begin
                t = d - s;
                cc_out.c = s > d;
            end
            default: t = '0;
        endcase
        ts = t[sb];
        cc_out.n = ts;
        cc_out.z = (t == '0);
        unique case (kind)
            K_CMP:   cc_out.v = (ss != ds) && (ts == ds);
            K_SUB:   cc_out.v = (ss != ds) && (ts == ss);
            K_ADD:   cc_out.v = (ss == ds) && (ts != ss);
            default: cc_out.v = 1'b0;
        endcase
        if (is_byte && kind == K_MOV && to_reg) begin
            res     = {{(W-BW){t[BW-1]}}, t[BW-1:0]};
            lo_only = 1'b0;
        end else begin
            res     = t;
            lo_only = is_byte;
        end
    end

endmodule

// File: rtl/dop_exec.sv
module dop_exec
    import dop_exec_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_code,
    input  logic [SW-1:0] sub_sel_i,
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  dst_i,
    input  logic          dst_is_reg,
    input  logic          ccw_en,
    input  logic [3:0]    ccw_data,
    output logic          out_valid,
    output logic [W-1:0]  result_o,
    output logic          result_we,
    output logic          result_lo_only,
    output logic [3:0]    cc_o,
    output logic          trap_o,
    output logic          fwd_o,
    output logic [SW-1:0] fwd_sel_o
);

    show_state_e state_q, state_d;
    op_kind_e    kind;
    logic        is_byte, writes, is_fwd, is_trap, lo_only;
    logic [W-1:0] alu_res;
    ccode_t      cc_q, alu_cc;

    dop_decode u_dec (
        .op_code (op_code),
        .kind    (kind),
        .is_byte (is_byte),
        .writes  (writes),
        .is_fwd  (is_fwd),
        .is_trap (is_trap)
    );

    dop_alu #(.W(W), .BW(BW)) u_alu (
        .kind    (kind),
        .is_byte (is_byte),
        .to_reg  (dst_is_reg),
        .src     (src_i),
        .dst     (dst_i),
        .c_in    (cc_q.c),
        .res     (alu_res),
        .lo_only (lo_only),
        .cc_out  (alu_cc)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q           <= '0;
            result_o       <= '0;
            result_we      <= 1'b0;
            result_lo_only <= 1'b0;
            trap_o         <= 1'b0;
            fwd_o          <= 1'b0;
            fwd_sel_o      <= '0;
        end else begin
            result_o       <= alu_res;
            result_we      <= in_valid && writes;
            result_lo_only <= in_valid && writes && lo_only;
            trap_o         <= in_valid && is_trap;
            fwd_o          <= in_valid && is_fwd;
            fwd_sel_o      <= sub_sel_i;
            if (ccw_en)
                cc_q <= ccw_data;
            else if (in_valid && !is_fwd && !is_trap)
                cc_q <= alu_cc;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
    assign cc_o      = cc_q;

endmodule

// File: rtl/dop_exec_chk.sv
module dop_exec_chk #(
    parameter int W  = 16,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          ccw_en,
    input logic [3:0]    ccw_data,
    input logic          out_valid,
    input logic          result_we,
    input logic          result_lo_only,
    input logic [3:0]    cc_o,
    input logic          trap_o,
    input logic          fwd_o,
    input logic [SW-1:0] fwd_sel_o,
    input logic [W-1:0]  result_o
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !$past(rst_n) |-> (!out_valid && cc_o == 4'h0)); // R12

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> out_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> (!out_valid && !result_we)); // R10

    AST_LO_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        result_lo_only |-> result_we); // R4

    AST_TRAP_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (!result_we && !fwd_o)); // R2

    AST_FWD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> !result_we); // R1

    AST_CC_HOLD_NONEXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (trap_o || fwd_o) && $past(rst_n) && !$past(ccw_en)) |-> $stable(cc_o)); // R1

    AST_CC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ccw_en)) |-> (cc_o == $past(ccw_data))); // R11

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_o, fwd_o, result_we})); // R2

    logic unused_ok;
    assign unused_ok = ^{fwd_sel_o, result_o};

endmodule

bind dop_exec dop_exec_chk #(.W(W), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .ccw_en         (ccw_en),
    .ccw_data       (ccw_data),
    .out_valid      (out_valid),
    .result_we      (result_we),
    .result_lo_only (result_lo_only),
    .cc_o           (cc_o),
    .trap_o         (trap_o),
    .fwd_o          (fwd_o),
    .fwd_sel_o      (fwd_sel_o),
    .result_o       (result_o)
);

// File: tb/sim_dop_exec.sv
module sim_dop_exec;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic        clk = 1'b0;
    logic        rst_n, in_valid, dst_is_reg, ccw_en;
    logic [3:0]  op_code, ccw_data;
    logic [2:0]  sub_sel_i;
    logic [15:0] src_i, dst_i;
    logic        out_valid, result_we, result_lo_only, trap_o, fwd_o;
    logic [15:0] result_o;
    logic [3:0]  cc_o;
    logic [2:0]  fwd_sel_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_cc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dop_exec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .sub_sel_i(sub_sel_i), .src_i(src_i), .dst_i(dst_i),
        .dst_is_reg(dst_is_reg), .ccw_en(ccw_en), .ccw_data(ccw_data),
        .out_valid(out_valid), .result_o(result_o), .result_we(result_we),
        .result_lo_only(result_lo_only), .cc_o(cc_o), .trap_o(trap_o),
        .fwd_o(fwd_o), .fwd_sel_o(fwd_sel_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic isreg);
        case (op)
            4'h0, 4'h7, 4'h8: return "R1";
            4'hF:             return "R2";
            4'h1:             return "R3";
            4'h9:             return isreg ? "R4" : "R3";
            4'h2:             return "R5";
            4'hE:             return "R6";
            4'h6:             return "R7";
            4'hA, 4'hB, 4'hC, 4'hD: return "R9";
            default:          return "R8";
        endcase
    endfunction

    // Reference model built from the requirements
    task automatic model(input logic [3:0] op, input logic [15:0] src, input logic [15:0] dst,
                         input logic isreg, input logic [3:0] cc_in,
                         output int res, output bit we, output bit lo,
                         output bit trp, output bit fwd, output logic [3:0] cc);
        bit byt = op[3] && op != 4'hE && op != 4'hF;
        int mask = byt ? 255 : 65535;
        int sgn  = byt ? 128 : 32768;
        int s = src & mask;
        int d = dst & mask;
        int t = 0;
        bit n, z, v, c, ss, ds, ts;
        ss = (s & sgn) != 0;
        ds = (d & sgn) != 0;
        v = 0; c = cc_in[0];
        we = 0; lo = 0; trp = 0; fwd = 0; res = 0;
        case (op)
            4'h0, 4'h7, 4'h8: fwd = 1;
            4'hF: trp = 1;
            4'h1, 4'h9: begin t = s; we = 1; end
            4'h2, 4'hA: begin
                t = (s - d) & mask; c = s < d;
                v = (ss != ds) && (((t & sgn) != 0) == ds);
            end
            4'h3, 4'hB: t = s & d;
            4'h4, 4'hC: begin t = d & ~s & mask; we = 1; end
            4'h5, 4'hD: begin t = d | s; we = 1; end
            4'h6: begin
                t = s + d; c = t > 65535; t = t & 65535; we = 1;
                v = (ss == ds) && (((t & sgn) != 0) != ss);
            end
            default: begin
                t = (d - s) & 65535; c = s > d; we = 1;
                v = (ss != ds) && (((t & sgn) != 0) == ss);
            end
        endcase
        ts = (t & sgn) != 0;
        n = ts; z = (t == 0);
        if (fwd || trp) cc = cc_in;
        else cc = {n, z, v, c};
        res = t;
        if (we && byt) begin
            if (op == 4'h9 && isreg) res = (t & 128) ? (t | 32'hFF00) : t;
            else lo = 1;
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input bit vld, input logic [3:0] op, input logic [2:0] sel,
                        input logic [15:0] s, input logic [15:0] d, input logic isreg,
                        input bit wen, input logic [3:0] wdata);
        int er; bit ewe, elo, etr, efw; logic [3:0] ecc;
        string tg;
        in_valid = vld; op_code = op; sub_sel_i = sel; src_i = s; dst_i = d;
        dst_is_reg = isreg; ccw_en = wen; ccw_data = wdata;
        model(op, s, d, isreg, exp_cc, er, ewe, elo, etr, efw, ecc);
        tg = tag_of(op, isreg);
        if (!vld) begin
            ewe = 0; etr = 0; efw = 0; ecc = exp_cc; tg = "R10";
        end
        if (wen) begin
            ecc = wdata; tg = "R11";
        end
        exp_cc = ecc;
        @(negedge clk);
        chk(out_valid == vld, "R10", "out_valid", out_valid, vld);
        chk(result_we == ewe, tg, "result_we", result_we, ewe);
        chk(trap_o == etr, tg, "trap", trap_o, etr);
        chk(fwd_o == efw, tg, "fwd", fwd_o, efw);
        chk(cc_o == ecc, tg, "cc", cc_o, ecc);
        if (ewe) begin
            chk(result_o == 16'(er), tg, "result", result_o, er);
            chk(result_lo_only == elo, tg, "lo_only", result_lo_only, elo);
        end
        if (efw) chk(fwd_sel_o == sel, tg, "fwd_sel", fwd_sel_o, sel);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int dummy;
        rst_n = 0; in_valid = 0; op_code = 0; sub_sel_i = 0; src_i = 0; dst_i = 0;
        dst_is_reg = 0; ccw_en = 0; ccw_data = 0;
        exp_cc = 4'h0;
        dummy = $urandom(SEED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(out_valid == 0, "R12", "out_valid after reset", out_valid, 0);
        chk(cc_o == 4'h0, "R12", "cc after reset", cc_o, 0);

        // R7 signed overflow and carry out
        step(1, 4'h6, 0, 16'h0001, 16'h7FFF, 0, 0, 0);
        step(1, 4'h6, 0, 16'h0001, 16'hFFFF, 0, 0, 0);
        // R5 / R6 same operands, opposite order
        step(1, 4'h2, 0, 16'h0000, 16'h0001, 0, 0, 0);
        step(1, 4'hE, 0, 16'h0000, 16'h0001, 0, 0, 0);
        step(1, 4'h2, 0, 16'h8000, 16'h0001, 0, 0, 0);
        step(1, 4'hE, 0, 16'h0001, 16'h8000, 0, 0, 0);
        // R9 byte compare with sign at bit 7 and dirty high byte
        step(1, 4'hA, 0, 16'hFF80, 16'h3301, 0, 0, 0);
        // R4 byte move, register and memory destinations
        step(1, 4'h9, 0, 16'h1280, 16'h0000, 1, 0, 0);
        step(1, 4'h9, 0, 16'h1280, 16'h0000, 0, 0, 0);
        step(1, 4'h9, 0, 16'hAB7F, 16'h0000, 1, 0, 0);
        // R8 logical ops keep C (set just before), clear V
        step(1, 4'h6, 0, 16'h0001, 16'hFFFF, 0, 0, 0);
        step(1, 4'hC, 0, 16'h00F0, 16'hFFFF, 0, 0, 0);
        step(1, 4'h3, 0, 16'h8000, 16'h8001, 0, 0, 0);
        step(1, 4'h5, 0, 16'h0000, 16'h0000, 0, 0, 0);
        // R1 / R2 non-executed codes
        step(1, 4'h0, 3'd5, 16'hFFFF, 16'h0000, 0, 0, 0);
        step(1, 4'h7, 3'd2, 16'h0000, 16'h0000, 0, 0, 0);
        step(1, 4'h8, 3'd7, 16'h8000, 16'h8000, 0, 0, 0);
        step(1, 4'hF, 0, 16'h0000, 16'h0000, 0, 0, 0);
        // R11 write port beats instruction flags
        step(1, 4'h1, 0, 16'h0000, 16'h0000, 0, 1, 4'hB);
        // R10 idle cycle
        step(0, 4'h1, 0, 16'h0000, 16'h0000, 0, 0, 0);
        step(0, 4'h1, 0, 16'h0000, 16'h0000, 0, 1, 4'h5);

        for (int i = 0; i < 600; i++) begin
            logic [15:0] s, d;
            bit vld, wen;
            s = 16'($urandom());
            d = 16'($urandom());
            if ($urandom_range(0, 3) == 0) s = s & 16'h80FF;
            if ($urandom_range(0, 5) == 0) d = s;
            vld = ($urandom_range(0, 7) != 0);
            wen = ($urandom_range(0, 9) == 0);
            step(vld, 4'($urandom()), 3'($urandom()), s, d, 1'($urandom()), wen, 4'($urandom()));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule